// File: doc/BRIEF.md
# Driver Readiness Supervisor

This block decides whether a gate driver may operate, using digitised measurements of its environment. It receives three measurement buses, each with a one-cycle valid strobe: the primary-side supply in millivolts, the secondary-side supply in millivolts, and the die temperature in degrees Celsius. Each measurement feeds its own monitor. Each monitor has two thresholds, so a reading that wanders near a limit does not make the status chatter.

The two supply monitors flag undervoltage. Each one trips when its reading falls below a lower limit and rearms when the reading rises above a higher limit. The thermal monitor works the other way round. It trips above a high temperature and rearms only once the temperature has dropped below a lower one. The driver is ready only when all three monitors are healthy.

The block outputs an active-low ready flag, meant for an open-drain style pad, and a gate-disable signal. The gate-disable signal holds the gate off whenever the driver is not ready. Recovery is automatic, with no reset pulse, once every condition has cleared.

Top module: `rdy_supervisor`

## Requirements
- R1: After reset both supplies count as undervoltage and the thermal monitor as healthy, so `ready_n` is 1 and `drive_block` is 1.
- R2: With `pri_vld` high, a primary reading strictly above PRI_GOOD_MV (default 2439) clears primary undervoltage, and a reading strictly below PRI_BAD_MV (default 2342) sets it.
- R3: With `sec_vld` high, a secondary reading strictly above SEC_GOOD_MV (default 11670) clears secondary undervoltage, and a reading strictly below SEC_BAD_MV (default 11270) sets it.
- R4: With `tmp_vld` high, a temperature strictly above TSD_ON_C (default 155) enters thermal shutdown, and one strictly below TSD_OFF_C (default 135) leaves it.
- R5: A valid reading in the band between a monitor's two thresholds, the thresholds themselves included, leaves that monitor's state unchanged.
- R6: A reading presented without its valid strobe has no effect on any monitor.
- R7: `ready_n` is 0 only when neither supply is in undervoltage and thermal shutdown is inactive. Any single condition drives it to 1.
- R8: `drive_block` is 1 whenever `ready_n` is 1, and 0 otherwise.
- R9: When the last active condition clears, `ready_n` returns to 0 on the clock edge that samples the clearing reading, with no reset required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_mv | input | MV_W (16) | Primary supply reading, unsigned millivolts |
| pri_vld | input | 1 | Primary reading valid strobe |
| sec_mv | input | MV_W (16) | Secondary supply reading, unsigned millivolts |
| sec_vld | input | 1 | Secondary reading valid strobe |
| tmp_c | input | TC_W (8) | Temperature reading, unsigned degrees Celsius |
| tmp_vld | input | 1 | Temperature reading valid strobe |
| ready_n | output | 1 | Active-low ready: 0 means ready to drive |
| drive_block | output | 1 | 1 forces the gate off |

## Verification
The assertions assume every reading is a plain unsigned code that is stable during the cycle its strobe is high. They also assume each trip threshold is below its rearm threshold for the supplies, and above it for temperature, so that no reading can satisfy both conditions of one monitor at once. The bench drives each bus at the falling edge with a one-cycle strobe and uses only the default thresholds. Its readings sit exactly on, one step past, and inside the hysteresis bands. Each monitor is exercised while the other two are held healthy, so that `ready_n` exposes that monitor alone.

// File: rtl/rdy_pkg.sv
package rdy_pkg;

    // Registered state of one hysteretic monitor.
    typedef struct packed {
        logic bad;
    } mon_st_t;

    // Index of each monitor in the combined condition vector.
    localparam int IDX_PRI = 0;
    localparam int IDX_SEC = 1;
    localparam int IDX_TMP = 2;
    localparam int N_MON   = 3;

endpackage

// File: rtl/hyst_mon.sv
module hyst_mon #(
    parameter int W         = 16,
    parameter int TRIP      = 0,    // crossing this marks the monitor bad
    parameter int REARM     = 0,    // crossing this marks it good again
    parameter bit HIGH_TRIP = 1'b0, // 1: bad above TRIP, 0: bad below TRIP
    parameter bit RST_BAD   = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld,
    input  logic [W-1:0] val,
    output logic         bad
);
    import rdy_pkg::*;

    localparam logic [W-1:0] TRIP_V  = W'(TRIP);
    localparam logic [W-1:0] REARM_V = W'(REARM);

    logic    trip_hit;
    logic    rearm_hit;
    mon_st_t st_d, st_q;

    generate
        if (HIGH_TRIP) begin : g_over
            assign trip_hit  = val > TRIP_V;
            assign rearm_hit = val < REARM_V;
        end else begin : g_under
            assign trip_hit  = val < TRIP_V;
            assign rearm_hit = val > REARM_V;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (vld) begin
            if (trip_hit)       st_d.bad = 1'b1;
            else if (rearm_hit) st_d.bad = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.bad <= RST_BAD;
        else        st_q     <= st_d;
    end

    assign bad = st_q.bad;

    // R6: nothing changes without a strobe
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(bad));

    // R5: reading inside the hysteresis band keeps the state
    p_band_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !trip_hit && !rearm_hit) |=> $stable(bad));

    // R2/R3/R4: a trip reading marks the monitor bad
    p_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && trip_hit) |=> bad);

    // R9: a rearm reading recovers without reset
    p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && rearm_hit && !trip_hit) |=> !bad);

endmodule

// File: rtl/rdy_combine.sv
module rdy_combine #(
    parameter int N = 3
) (
    input  logic [N-1:0] cond_bad,
    output logic         ready_n,
    output logic         drive_block
);
    logic any_bad;

    always_comb begin
        any_bad = 1'b0;
        for (int i = 0; i < N; i++) any_bad = any_bad | cond_bad[i];
    end

    assign ready_n     = any_bad;
    assign drive_block = any_bad;

endmodule

// File: rtl/rdy_supervisor.sv
module rdy_supervisor #(
    parameter int MV_W        = 16,
    parameter int TC_W        = 8,
    parameter int PRI_GOOD_MV = 2439,
    parameter int PRI_BAD_MV  = 2342,
    parameter int SEC_GOOD_MV = 11670,
    parameter int SEC_BAD_MV  = 11270,
    parameter int TSD_ON_C    = 155,
    parameter int TSD_OFF_C   = 135
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [MV_W-1:0] pri_mv,
    input  logic            pri_vld,
    input  logic [MV_W-1:0] sec_mv,
    input  logic            sec_vld,
    input  logic [TC_W-1:0] tmp_c,
    input  logic            tmp_vld,
    output logic            ready_n,
    output logic            drive_block
);
    import rdy_pkg::*;

    localparam logic [MV_W-1:0] PRI_BAD_V = MV_W'(PRI_BAD_MV);
    localparam logic [TC_W-1:0] TSD_ON_V  = TC_W'(TSD_ON_C);

    logic [N_MON-1:0] cond_bad;

    hyst_mon #(.W(MV_W), .TRIP(PRI_BAD_MV), .REARM(PRI_GOOD_MV),
               .HIGH_TRIP(1'b0), .RST_BAD(1'b1)) u_pri (
        .clk(clk), .rst_n(rst_n), .vld(pri_vld), .val(pri_mv),
        .bad(cond_bad[IDX_PRI]));

    hyst_mon #(.W(MV_W), .TRIP(SEC_BAD_MV), .REARM(SEC_GOOD_MV),
               .HIGH_TRIP(1'b0), .RST_BAD(1'b1)) u_sec (
        .clk(clk), .rst_n(rst_n), .vld(sec_vld), .val(sec_mv),
        .bad(cond_bad[IDX_SEC]));

    hyst_mon #(.W(TC_W), .TRIP(TSD_ON_C), .REARM(TSD_OFF_C),
               .HIGH_TRIP(1'b1), .RST_BAD(1'b0)) u_tmp (
        .clk(clk), .rst_n(rst_n), .vld(tmp_vld), .val(tmp_c),
        .bad(cond_bad[IDX_TMP]));

    rdy_combine #(.N(N_MON)) u_comb (
        .cond_bad(cond_bad), .ready_n(ready_n), .drive_block(drive_block));

    // R7: a primary undervoltage reading withdraws ready on the next cycle
    p_pri_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_vld && pri_mv < PRI_BAD_V) |=> ready_n);

    // R7: an over-temperature reading withdraws ready on the next cycle
    p_hot_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmp_vld && tmp_c > TSD_ON_V) |=> ready_n);

    // R8: gate held off whenever not ready
    p_gate_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready_n |-> drive_block);

endmodule

// File: tb/rdy_supervisor_tb.sv
module rdy_supervisor_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pri_mv = '0;
    logic        pri_vld = 1'b0;
    logic [15:0] sec_mv = '0;
    logic        sec_vld = 1'b0;
    logic [7:0]  tmp_c = '0;
    logic        tmp_vld = 1'b0;
    logic        ready_n;
    logic        drive_block;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdy_supervisor u_dut (
        .clk(clk), .rst_n(rst_n),
        .pri_mv(pri_mv), .pri_vld(pri_vld),
        .sec_mv(sec_mv), .sec_vld(sec_vld),
        .tmp_c(tmp_c), .tmp_vld(tmp_vld),
        .ready_n(ready_n), .drive_block(drive_block));

    task automatic chk(input logic exp_rn, input string req);
        checks++;
        if (ready_n !== exp_rn) begin
            errors++;
            $display("FAIL %s ready_n actual=%b expected=%b", req, ready_n, exp_rn);
        end
        checks++;
        if (drive_block !== exp_rn) begin
            errors++;
            $display("FAIL R8 (%s) drive_block actual=%b expected=%b", req, drive_block, exp_rn);
        end
    endtask

    // Present one reading with a one-cycle strobe; sample at the following falling edge.
    task automatic put(input int which, input int value);
        @(negedge clk);
        case (which)
            0: begin pri_mv = 16'(value); pri_vld = 1'b1; end
            1: begin sec_mv = 16'(value); sec_vld = 1'b1; end
            default: begin tmp_c = 8'(value); tmp_vld = 1'b1; end
        endcase
        @(negedge clk);
        pri_vld = 1'b0; sec_vld = 1'b0; tmp_vld = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(1'b1, "R1");
        put(1, 11700);
        put(2, 25);
        chk(1'b1, "R1 primary still bad");
    endtask

    task automatic t_primary();
        put(0, 2440); chk(1'b0, "R2 rearm R9");
        put(0, 2439); chk(1'b0, "R5 at rearm");
        put(0, 2342); chk(1'b0, "R5 at trip");
        put(0, 2341); chk(1'b1, "R2 trip");
        put(0, 2400); chk(1'b1, "R5 band");
        put(0, 2439); chk(1'b1, "R5 at rearm");
        put(0, 2440); chk(1'b0, "R9 recover");
    endtask

    task automatic t_secondary();
        put(1, 11270); chk(1'b0, "R5 sec at trip");
        put(1, 11269); chk(1'b1, "R3 trip");
        put(1, 11670); chk(1'b1, "R5 sec at rearm");
        put(1, 11671); chk(1'b0, "R3 rearm");
    endtask

    task automatic t_thermal();
        put(2, 155); chk(1'b0, "R5 at tsd on");
        put(2, 156); chk(1'b1, "R4 enter");
        put(2, 140); chk(1'b1, "R5 tsd band");
        put(2, 135); chk(1'b1, "R5 at tsd off");
        put(2, 134); chk(1'b0, "R4 leave R9");
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        pri_mv = 16'd100; sec_mv = 16'd100; tmp_c = 8'd250;
        repeat (3) @(negedge clk);
        chk(1'b0, "R6 no strobe");
    endtask

    task automatic t_combine();
        put(0, 2000); put(2, 200); chk(1'b1, "R7 two bad");
        put(0, 3000); chk(1'b1, "R7 one left");
        put(1, 9000); chk(1'b1, "R7 sec added");
        put(2, 50);   chk(1'b1, "R7 sec remains");
        put(1, 12000); chk(1'b0, "R7 all good R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_primary();
        t_secondary();
        t_thermal();
        t_no_strobe();
        t_combine();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule